// File: doc/BRIEF.md
# Monitor Command and Readback Slave

This block is the two-wire serial slave that sits in front of a voltage and current monitor. It watches SCL and SDA, answers its own 7-bit address, and decodes the bytes a bus master writes. A written byte is either a command byte, which picks the channels, the conversion mode and the voltage range, or a pointer to one of three extended registers, which is followed by the value for that register. Reads return the latest conversion results, packed into two or three bytes depending on which channels the last command selected. A read can instead return one status byte taken from the surrounding logic.

Conversions are requested from an external converter through a request/done handshake. The converter delivers a 12-bit voltage code and a 12-bit current code. A conversion starts in one of three ways: a one-shot command, continuous mode, or a rising level on the convert input. While a one-shot conversion is outstanding, the slave refuses read addresses so that a master never reads stale data. SCL, SDA and the convert input are sampled by a system clock that runs at least eight times the bus bit rate. SDA is driven only as a pull-low enable.

Top module: `mon_i2c_front`

## Requirements
- R1: The slave acknowledges only the 7-bit address formed by the prefix 11010 followed by the two strap bits (strap bit 1 then bit 0), sent MSB first with R/W as the eighth bit (0 = write, 1 = read). Any other address gets no acknowledge, and the slave stays silent until the next start.
- R2: A data byte with bit 7 = 0 is a command. Its fields are: bit 0 continuous voltage, bit 1 one-shot voltage, bit 2 continuous current, bit 3 one-shot current, bit 4 range, bit 6 status select; bit 5 is ignored. A one-shot command raises the converter request with the voltage and current select outputs equal to bits 1 and 3.
- R3: A data byte with bit 7 = 1 points to an extended register through bits 1:0 (01 alert enable, 10 alert threshold, 11 control). The next data byte of the same transfer is stored there. The pointer value 00 stores nothing.
- R4: When the last command selected both channels, a read returns three bytes: voltage[11:4], current[11:4], then {voltage[3:0], current[3:0]}.
- R5: When the last command selected one channel, a read returns two bytes: code[11:4], then {code[3:0], 4'b0000}.
- R6: One-shot bits are not kept; after a one-shot conversion finishes, no further request is made. A read address is not acknowledged while a one-shot conversion is waiting or running, and is acknowledged once it has completed.
- R7: In continuous mode the converter is requested again after every completion until a command clears the continuous bits. A command byte clears the held results, so a read before the first completion is acknowledged and returns zeros.
- R8: With the status-select bit set, a read returns the status input as a single byte. This read is acknowledged even while a one-shot conversion is outstanding.
- R9: A rising level on the convert input starts a conversion of the channels chosen by the stored command. This conversion counts as a one-shot, so reads are refused until it completes.
- R10: An address with the write bit and no data bytes (a quick command) is acknowledged and changes no register, no request and no read data.
- R11: The converter request stays high until the cycle in which done is seen, and is low in the cycle after that.
- R12: The slave changes its SDA pull-low only while the sampled SCL is low.
- R13: The range output follows bit 4 of the most recent command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_strap_i | input | 2 | Low two address bits |
| conv_i | input | 1 | Convert request input, active high |
| adc_req_o | output | 1 | Converter request, held until done |
| adc_sel_v_o | output | 1 | Voltage channel selected for the current conversion |
| adc_sel_i_o | output | 1 | Current channel selected for the current conversion |
| adc_range_o | output | 1 | Voltage range select |
| adc_done_i | input | 1 | One-cycle completion pulse from the converter |
| adc_vcode_i | input | 12 | Voltage code, valid with done |
| adc_icode_i | input | 12 | Current code, valid with done |
| status_i | input | 8 | Status byte returned by a status read |
| alert_en_o | output | 8 | Alert enable register |
| alert_thr_o | output | 8 | Alert threshold register |
| ctrl_o | output | 8 | Control register |

## Verification
The slave sees each bus edge through a two-stage synchronizer plus one edge-detect register. Its SDA drive therefore changes three system cycles after an SCL fall. The bench holds every SCL phase for eight cycles and samples SDA in the middle of the high phase. A written byte takes effect within about five cycles of its eighth rising SCL edge, and the converter request rises one cycle after that. So register outputs and request selects are checked only after the stop condition, tens of cycles later. The modelled converter takes 400 cycles, which is longer than an address phase, so reads issued right after a one-shot command reliably find it outstanding. Request release is checked on every falling clock edge one cycle after each done pulse, and SDA drive changes are checked against SCL on every falling clock edge.

// File: rtl/mon_pkg.sv
package mon_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_ACK_SET, S_ACK_HOLD, S_WR, S_RD, S_RD_ACK
   } bus_st_t;

   localparam int BYTE_W     = 8;
   localparam int RD_BYTES   = 3;
   localparam int RD_W       = RD_BYTES * BYTE_W;

   localparam int CB_CONT_V  = 0;
   localparam int CB_ONE_V   = 1;
   localparam int CB_CONT_I  = 2;
   localparam int CB_ONE_I   = 3;
   localparam int CB_RANGE   = 4;
   localparam int CB_STATUS  = 6;
   localparam int CB_EXT     = 7;

   localparam logic [1:0] XR_ALERT_EN  = 2'b01;
   localparam logic [1:0] XR_ALERT_THR = 2'b10;
   localparam logic [1:0] XR_CTRL      = 2'b11;
endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d_i};
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mon_i2c_slave.sv
module mon_i2c_slave
   import mon_pkg::*;
#(
   parameter logic [4:0] ADDR_PREFIX = 5'b11010
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_s,
   input  logic            sda_s,
   input  logic [1:0]      strap,
   input  logic            rd_ok,
   input  logic [RD_W-1:0] rd_bytes,
   output logic            sda_oe,
   output logic            wr_stb,
   output logic [7:0]      wr_data,
   output logic            bus_start
);
   logic            scl_q, sda_q;
   bus_st_t         st;
   logic [6:0]      sh;
   logic [3:0]      bitcnt;
   logic            rd_mode;
   logic            mack;
   logic [RD_W-1:0] snap;
   logic [7:0]      txb;

   logic       rise, fall, start_c, stop_c;
   logic [7:0] byte_in;
   logic [6:0] my_addr;

   assign rise    = scl_s & ~scl_q;
   assign fall    = ~scl_s & scl_q;
   assign start_c = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;
   assign byte_in = {sh, sda_s};
   assign my_addr = {ADDR_PREFIX, strap};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;  sda_q <= 1'b1;  st <= S_IDLE;
         sh <= '0;  bitcnt <= '0;  rd_mode <= 1'b0;  mack <= 1'b0;
         snap <= '0;  txb <= '0;  sda_oe <= 1'b0;
         wr_stb <= 1'b0;  wr_data <= '0;  bus_start <= 1'b0;
      end else begin
         scl_q     <= scl_s;
         sda_q     <= sda_s;
         wr_stb    <= 1'b0;
         bus_start <= 1'b0;
         if (start_c) begin
            st <= S_ADDR;  bitcnt <= '0;  sda_oe <= 1'b0;  bus_start <= 1'b1;
         end else if (stop_c) begin
            st <= S_IDLE;  sda_oe <= 1'b0;
         end else begin
            case (st)
               S_ADDR: if (rise) begin
                  sh     <= byte_in[6:0];
                  bitcnt <= bitcnt + 4'd1;
                  if (bitcnt == 4'd7) begin
                     bitcnt <= '0;
                     if (byte_in[7:1] == my_addr && (!byte_in[0] || rd_ok)) begin
                        st      <= S_ACK_SET;
                        rd_mode <= byte_in[0];
                        snap    <= rd_bytes;
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               S_ACK_SET: if (fall) begin
                  sda_oe <= 1'b1;
                  st     <= S_ACK_HOLD;
               end
               S_ACK_HOLD: if (fall) begin
                  if (rd_mode) begin
                     txb    <= snap[RD_W-1 -: 8];
                     snap   <= {snap[RD_W-9:0], 8'h00};
                     sda_oe <= ~snap[RD_W-1];
                     bitcnt <= 4'd1;
                     st     <= S_RD;
                  end else begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     st     <= S_WR;
                  end
               end
               S_WR: if (rise) begin
                  sh     <= byte_in[6:0];
                  bitcnt <= bitcnt + 4'd1;
                  if (bitcnt == 4'd7) begin
                     bitcnt  <= '0;
                     wr_stb  <= 1'b1;
                     wr_data <= byte_in;
                     rd_mode <= 1'b0;
                     st      <= S_ACK_SET;
                  end
               end
               S_RD: if (fall) begin
                  if (bitcnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     st     <= S_RD_ACK;
                  end else begin
                     txb    <= {txb[6:0], 1'b0};
                     sda_oe <= ~txb[6];
                     bitcnt <= bitcnt + 4'd1;
                  end
               end
               S_RD_ACK: begin
                  if (rise) mack <= ~sda_s;
                  if (fall) begin
                     if (mack) begin
                        txb    <= snap[RD_W-1 -: 8];
                        snap   <= {snap[RD_W-9:0], 8'h00};
                        sda_oe <= ~snap[RD_W-1];
                        bitcnt <= 4'd1;
                        st     <= S_RD;
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12: SDA pull-low only starts in a cycle after SCL was seen low
   assert_sda_setup_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_s));

   // R12: a start condition never leaves SDA driven
   assert_start_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> !sda_oe);
endmodule

// File: rtl/mon_conv_ctrl.sv
module mon_conv_ctrl
   import mon_pkg::*;
#(
   parameter int ADC_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_stb,
   input  logic [7:0]      wr_data,
   input  logic            bus_start,
   input  logic            conv_s,
   input  logic            adc_done,
   input  logic [ADC_W-1:0] adc_vcode,
   input  logic [ADC_W-1:0] adc_icode,
   input  logic [7:0]      status_in,
   output logic            adc_req,
   output logic            sel_v,
   output logic            sel_i,
   output logic            range_o,
   output logic [7:0]      alert_en,
   output logic [7:0]      alert_thr,
   output logic [7:0]      ctrl,
   output logic            rd_ok,
   output logic [RD_W-1:0] rd_bytes
);
   localparam int LO_W = ADC_W - BYTE_W;

   logic conv_q, cont_v, cont_i, cfg_v, cfg_i, stat_sel;
   logic ext_pend;
   logic [1:0] ext_sel;
   logic os_req, pv, pi, inflight;
   logic [ADC_W-1:0] res_v, res_i;
   logic conv_rise, cmd_stb, unused_bit5;

   assign conv_rise   = conv_s & ~conv_q;
   assign cmd_stb     = wr_stb & ~ext_pend & ~wr_data[CB_EXT];
   assign unused_bit5 = wr_data[5];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q <= 1'b0;  cont_v <= 1'b0;  cont_i <= 1'b0;
         cfg_v <= 1'b0;  cfg_i <= 1'b0;  stat_sel <= 1'b0;  range_o <= 1'b0;
         ext_pend <= 1'b0;  ext_sel <= '0;
         alert_en <= '0;  alert_thr <= '0;  ctrl <= '0;
         os_req <= 1'b0;  pv <= 1'b0;  pi <= 1'b0;  inflight <= 1'b0;
         adc_req <= 1'b0;  sel_v <= 1'b0;  sel_i <= 1'b0;
         res_v <= '0;  res_i <= '0;
      end else begin
         conv_q <= conv_s;
         // converter handshake
         if (adc_req) begin
            if (adc_done) begin
               adc_req  <= 1'b0;
               inflight <= 1'b0;
               if (sel_v) res_v <= adc_vcode;
               if (sel_i) res_i <= adc_icode;
            end
         end else if (os_req) begin
            adc_req <= 1'b1;  sel_v <= pv;  sel_i <= pi;
            inflight <= 1'b1;  os_req <= 1'b0;
         end else if (cont_v | cont_i) begin
            adc_req <= 1'b1;  sel_v <= cont_v;  sel_i <= cont_i;
         end
         // convert input
         if (conv_rise && (cfg_v | cfg_i)) begin
            os_req <= 1'b1;  pv <= cfg_v;  pi <= cfg_i;
         end
         if (bus_start) ext_pend <= 1'b0;
         // bus writes
         if (wr_stb) begin
            if (ext_pend) begin
               ext_pend <= 1'b0;
               case (ext_sel)
                  XR_ALERT_EN:  alert_en  <= wr_data;
                  XR_ALERT_THR: alert_thr <= wr_data;
                  XR_CTRL:      ctrl      <= wr_data;
                  default: ;
               endcase
            end else if (wr_data[CB_EXT]) begin
               ext_sel  <= wr_data[1:0];
               ext_pend <= 1'b1;
            end else begin
               cont_v   <= wr_data[CB_CONT_V];
               cont_i   <= wr_data[CB_CONT_I];
               cfg_v    <= wr_data[CB_CONT_V] | wr_data[CB_ONE_V];
               cfg_i    <= wr_data[CB_CONT_I] | wr_data[CB_ONE_I];
               range_o  <= wr_data[CB_RANGE];
               stat_sel <= wr_data[CB_STATUS];
               res_v    <= '0;
               res_i    <= '0;
               if (wr_data[CB_ONE_V] | wr_data[CB_ONE_I]) begin
                  os_req <= 1'b1;
                  pv     <= wr_data[CB_ONE_V];
                  pi     <= wr_data[CB_ONE_I];
               end
            end
         end
      end
   end

   assign rd_ok = stat_sel | ~(os_req | inflight);

   always_comb begin
      rd_bytes = '0;
      if (stat_sel) begin
         rd_bytes = {status_in, 16'h0000};
      end else begin
         case ({cfg_v, cfg_i})
            2'b11: rd_bytes = {res_v[ADC_W-1 -: BYTE_W], res_i[ADC_W-1 -: BYTE_W],
                               res_v[LO_W-1:0], res_i[LO_W-1:0]};
            2'b10: rd_bytes = {res_v[ADC_W-1 -: BYTE_W], res_v[LO_W-1:0],
                               {(16-LO_W){1'b0}}};
            2'b01: rd_bytes = {res_i[ADC_W-1 -: BYTE_W], res_i[LO_W-1:0],
                               {(16-LO_W){1'b0}}};
            default: rd_bytes = '0;
         endcase
      end
   end

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req && !adc_done |=> adc_req);

   assert_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req && adc_done |=> !adc_req);

   assert_oneshot_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb && !wr_data[CB_STATUS] && (wr_data[CB_ONE_V] | wr_data[CB_ONE_I])
      |=> !rd_ok);

   assert_cmd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb && !wr_data[CB_STATUS] |=> rd_bytes == '0);
endmodule

// File: rtl/mon_i2c_front.sv
module mon_i2c_front
   import mon_pkg::*;
#(
   parameter int ADC_W = 12,
   parameter int SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_PREFIX = 5'b11010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic [1:0]       addr_strap_i,
   input  logic             conv_i,
   output logic             adc_req_o,
   output logic             adc_sel_v_o,
   output logic             adc_sel_i_o,
   output logic             adc_range_o,
   input  logic             adc_done_i,
   input  logic [ADC_W-1:0] adc_vcode_i,
   input  logic [ADC_W-1:0] adc_icode_i,
   input  logic [7:0]       status_i,
   output logic [7:0]       alert_en_o,
   output logic [7:0]       alert_thr_o,
   output logic [7:0]       ctrl_o
);
   if (ADC_W != 12) begin : g_bad_width
      $error("mon_i2c_front: readback packing needs ADC_W == 12");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mon_i2c_front: SYNC_STAGES must be at least 2");
   end

   logic [2:0] pins_s;
   logic scl_s, sda_s, conv_s;
   logic wr_stb, bus_start, rd_ok;
   logic [7:0] wr_data;
   logic [RD_W-1:0] rd_bytes;

   mon_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i, conv_i}), .q_o(pins_s));

   assign {scl_s, sda_s, conv_s} = pins_s;

   mon_i2c_slave #(.ADDR_PREFIX(ADDR_PREFIX)) u_slave (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .strap(addr_strap_i), .rd_ok(rd_ok), .rd_bytes(rd_bytes),
      .sda_oe(sda_oe_o), .wr_stb(wr_stb), .wr_data(wr_data),
      .bus_start(bus_start));

   mon_conv_ctrl #(.ADC_W(ADC_W)) u_conv (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .bus_start(bus_start), .conv_s(conv_s), .adc_done(adc_done_i),
      .adc_vcode(adc_vcode_i), .adc_icode(adc_icode_i), .status_in(status_i),
      .adc_req(adc_req_o), .sel_v(adc_sel_v_o), .sel_i(adc_sel_i_o),
      .range_o(adc_range_o), .alert_en(alert_en_o), .alert_thr(alert_thr_o),
      .ctrl(ctrl_o), .rd_ok(rd_ok), .rd_bytes(rd_bytes));
endmodule

// File: tb/mon_i2c_front_tb.sv
module mon_i2c_front_tb;
   localparam int H = 8;
   localparam int ADC_LAT = 400;
   localparam logic [7:0] AW = 8'hD4, AR = 8'hD5, ABAD = 8'hD6;
   localparam logic [11:0] VC = 12'hA5C, IC = 12'h3B7;
   localparam logic [7:0] STAT = 8'h96;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tb_scl = 1'b1, tb_sda = 1'b1, conv = 1'b0;
   logic sda_oe, sda_line;
   logic adc_req, sel_v, sel_i, rng, adc_done = 1'b0;
   logic [7:0] aen, athr, ctl;
   int checks = 0, failures = 0, lat = 0, req_rises = 0;
   logic req_q = 1'b0, prev_done = 1'b0, prev_oe = 1'b0;

   always #2 clk = ~clk;
   assign sda_line = tb_sda & ~sda_oe;

   mon_i2c_front u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(tb_scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .addr_strap_i(2'b10), .conv_i(conv),
      .adc_req_o(adc_req), .adc_sel_v_o(sel_v), .adc_sel_i_o(sel_i),
      .adc_range_o(rng), .adc_done_i(adc_done), .adc_vcode_i(VC),
      .adc_icode_i(IC), .status_i(STAT), .alert_en_o(aen),
      .alert_thr_o(athr), .ctrl_o(ctl));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // converter model
   always @(posedge clk) begin
      adc_done <= 1'b0;
      if (rst_n && adc_req && !adc_done) begin
         if (lat == ADC_LAT - 1) begin adc_done <= 1'b1; lat <= 0; end
         else lat <= lat + 1;
      end
      req_q <= adc_req;
      if (adc_req && !req_q) req_rises <= req_rises + 1;
   end

   // per-clock protocol monitors
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done) check("R11 request low after done", adc_req, 0);
         if (sda_oe !== prev_oe) check("R12 sda drive change with scl low", tb_scl, 0);
      end
      prev_done <= adc_done;
      prev_oe   <= sda_oe;
   end

   task automatic cyc(input int n); repeat (n) @(posedge clk); endtask

   task automatic b_start();
      tb_sda <= 1'b1; tb_scl <= 1'b1; cyc(H);
      tb_sda <= 1'b0; cyc(H);
      tb_scl <= 1'b0; cyc(2);
   endtask

   task automatic b_stop();
      tb_sda <= 1'b0; cyc(H);
      tb_scl <= 1'b1; cyc(H);
      tb_sda <= 1'b1; cyc(H);
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         tb_sda <= b[i]; cyc(H);
         tb_scl <= 1'b1; cyc(H);
         tb_scl <= 1'b0; cyc(2);
      end
      tb_sda <= 1'b1; cyc(H);
      tb_scl <= 1'b1; cyc(H/2);
      @(negedge clk) ack = (sda_line == 1'b0);
      cyc(H/2);
      tb_scl <= 1'b0; cyc(2);
   endtask

   task automatic rbyte(input logic mack, output logic [7:0] b);
      tb_sda <= 1'b1;
      for (int i = 7; i >= 0; i--) begin
         cyc(H);
         tb_scl <= 1'b1; cyc(H/2);
         @(negedge clk) b[i] = sda_line;
         cyc(H/2);
         tb_scl <= 1'b0; cyc(2);
      end
      tb_sda <= mack ? 1'b0 : 1'b1; cyc(H);
      tb_scl <= 1'b1; cyc(H);
      tb_scl <= 1'b0; cyc(2);
      tb_sda <= 1'b1;
   endtask

   task automatic wr_txn(input logic [7:0] a, input int n, input logic [7:0] d0,
                         input logic [7:0] d1, output logic ok);
      logic ak;
      b_start();
      wbyte(a, ak); ok = ak;
      if (ak && n > 0) begin wbyte(d0, ak); ok = ok & ak; end
      if (ak && n > 1) begin wbyte(d1, ak); ok = ok & ak; end
      b_stop();
   endtask

   task automatic rd_txn(input int n, output logic ak, output logic [23:0] d);
      logic [7:0] b;
      d = '0;
      b_start();
      wbyte(AR, ak);
      if (ak) for (int k = 0; k < n; k++) begin
         rbyte(k != n - 1, b);
         d = d | (24'(b) << (16 - 8 * k));
      end
      b_stop();
   endtask

   task automatic wait_conv();
      for (int k = 0; k < 5000; k++) begin
         @(posedge clk);
         if (!adc_req) break;
      end
      cyc(4);
   endtask

   // reference packing, computed from the requirement text
   function automatic logic [23:0] ref_pack(input bit v, input bit i);
      int hv = VC / 16, lv = VC % 16, hi = IC / 16, li = IC % 16;
      if (v && i) return 24'((hv << 16) + (hi << 8) + lv * 16 + li);
      if (v) return 24'((hv << 16) + (lv << 12));
      if (i) return 24'((hi << 16) + (li << 12));
      return 24'd0;
   endfunction

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic ok, ak;
      logic [23:0] d;
      int r0;
      cyc(10); rst_n <= 1'b1; cyc(5);
      check("reset sda_oe", sda_oe, 0);
      check("reset adc_req", adc_req, 0);
      check("reset regs", {aen, athr, ctl}, 0);
      check("reset range", rng, 0);

      // R1 address decode
      wr_txn(ABAD, 0, 8'h00, 8'h00, ok);
      check("R1 foreign address not acked", ok, 0);
      // R10 quick command
      wr_txn(AW, 0, 8'h00, 8'h00, ok);
      check("R1 own address acked", ok, 1);
      cyc(20);
      check("R10 quick command no request", adc_req, 0);
      check("R10 quick command no register change", {aen, athr, ctl, 7'd0, rng}, 0);

      // R3 extended registers
      wr_txn(AW, 2, 8'h81, 8'h5A, ok);
      wr_txn(AW, 2, 8'h82, 8'h33, ok);
      wr_txn(AW, 2, 8'h83, 8'hC4, ok);
      check("R3 writes acked", ok, 1);
      check("R3 alert enable", aen, 8'h5A);
      check("R3 alert threshold", athr, 8'h33);
      check("R3 control", ctl, 8'hC4);
      wr_txn(AW, 2, 8'h80, 8'h77, ok);
      check("R3 pointer 00 stores nothing", {aen, athr, ctl}, {8'h5A, 8'h33, 8'hC4});

      // R2/R4/R6 one-shot both channels
      wr_txn(AW, 1, 8'h0A, 8'h00, ok);
      check("R2 one-shot request raised", {adc_req, sel_v, sel_i}, 3'b111);
      rd_txn(3, ak, d);
      check("R6 read refused while pending", ak, 0);
      wait_conv();
      rd_txn(3, ak, d);
      check("R6 read acked after completion", ak, 1);
      check("R4 three-byte packing", d, ref_pack(1, 1));
      r0 = req_rises; cyc(600);
      check("R6 one-shot bits not kept", req_rises - r0, 0);

      // R5/R13 voltage only with range
      wr_txn(AW, 1, 8'h12, 8'h00, ok);
      check("R13 range set", rng, 1);
      check("R2 voltage only select", {sel_v, sel_i}, 2'b10);
      wait_conv();
      rd_txn(2, ak, d);
      check("R5 voltage two-byte packing", d, ref_pack(1, 0));

      // R5 current only
      wr_txn(AW, 1, 8'h08, 8'h00, ok);
      check("R13 range cleared", rng, 0);
      wait_conv();
      rd_txn(2, ak, d);
      check("R5 current two-byte packing", d, ref_pack(0, 1));

      // R9 convert input, channels from stored command (current only)
      conv <= 1'b1; cyc(20); conv <= 1'b0; cyc(2);
      check("R9 convert input request", {adc_req, sel_v, sel_i}, 3'b101);
      rd_txn(2, ak, d);
      check("R9 read refused during pin conversion", ak, 0);
      wait_conv();
      rd_txn(2, ak, d);
      check("R9 pin conversion data", {7'd0, ak, d}, {8'd1, ref_pack(0, 1)});

      // R8 status read, also while a one-shot is pending
      wr_txn(AW, 1, 8'h4A, 8'h00, ok);
      rd_txn(1, ak, d);
      check("R8 status read acked while pending", ak, 1);
      check("R8 status byte", d[23:16], STAT);
      wait_conv();

      // R7 continuous voltage
      wr_txn(AW, 1, 8'h01, 8'h00, ok);
      rd_txn(2, ak, d);
      check("R7 early continuous read acked", ak, 1);
      check("R7 early continuous read zeros", d, 0);
      r0 = req_rises; cyc(1200);
      check("R7 repeated requests", (req_rises - r0) >= 2, 1);
      rd_txn(2, ak, d);
      check("R7 continuous data", d, ref_pack(1, 0));
      wr_txn(AW, 1, 8'h00, 8'h00, ok);
      cyc(1000);
      check("R7 continuous stops", adc_req, 0);

      // R10 quick command leaves configuration alone
      wr_txn(AW, 1, 8'h02, 8'h00, ok);
      wait_conv();
      wr_txn(AW, 0, 8'h00, 8'h00, ok);
      check("R10 quick command acked", ok, 1);
      rd_txn(2, ak, d);
      check("R10 read data unchanged after quick command", d, ref_pack(1, 0));

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule